// File: doc/BRIEF.md
# Configuration Space Register File

This block is the register side of a plug-and-play expansion target. It models a 256-byte configuration space that software reads and writes one 32-bit doubleword at a time. It takes a doubleword index, a write strobe with per-byte enables and a read strobe. Read data comes back from a register one clock after the read strobe. The block does not handle the bus protocol itself: address/data multiplexing, parity and initiator logic sit in neighbouring blocks, which drive this port.

The first 64 bytes hold the standard header. Identification and class fields are fixed by parameters. Software sees a command word and a status word whose error flags are set by hardware events and cleared by writing ones. Three base address registers cover a memory window, an I/O window and an expansion ROM window. Each one stores only the bits above its window size, so writing all ones and reading back tells software how large the window is. A device-present input makes the whole space read as all ones and ignore writes, which is the value a host takes to mean that no unit is installed.

Top module: `cfg_space_regs`

## Requirements
- R1: After synchronous reset, rd_valid_o and rd_data_o are 0, the command word and all status error flags are 0, and every base address register holds zero in its writable bits.
- R2: While present_i is 1, a read of index 0 returns DEVICE_ID in bits 31:16 and VENDOR_ID in bits 15:0, and writes to index 0 change nothing.
- R3: While present_i is 0, every read returns 32'hFFFF_FFFF and writes change no register.
- R4: A read of index 2 returns CLASS_CODE in bits 31:16 and VENDOR_DEF in bits 15:0, and writes to index 2 change nothing.
- R5: At index 1, command bits 15:0 are read/write only where CMD_MASK has a 1, with wr_be_i[0] gating bits 7:0 and wr_be_i[1] gating bits 15:8. Every other command bit reads 0.
- R6: Status error flag k sits at bit 27+k of index 1, for k from 0 to 4. A 1 on err_evt_i[k] sets it. Writing 1 to that bit with wr_be_i[3]=1 clears it, and writing 0 leaves it as it is. When a set and a clear land in the same cycle, the set wins. Bits 26:16 read 0.
- R7: The memory window register at index 4 (byte 10H) stores bits 31:MEM_LOG2 under byte enables, and bits MEM_LOG2-1:0 read 0.
- R8: The I/O window register at index 5 (byte 14H) stores bits 31:IO_LOG2 under byte enables. Bit 0 always reads 1, and the other low bits read 0.
- R9: The ROM window register at index 12 (byte 30H) stores bits 31:ROM_LOG2 and the enable bit 0 under byte enables. Bits ROM_LOG2-1:1 read 0.
- R10: Every other index, including all of 16 to 63 (bytes 40H to FFH), reads 0, and writes to it have no visible effect.
- R11: rd_valid_o is 1 exactly one cycle after rd_en_i, and rd_data_o holds its last value when no read is issued. A read and a write to the same index in one cycle return the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| present_i | input | 1 | Unit installed; 0 forces all-ones reads and blocks writes |
| rd_en_i | input | 1 | Read strobe |
| wr_en_i | input | 1 | Write strobe |
| idx_i | input | 6 | Doubleword index (byte address / 4) |
| wr_data_i | input | 32 | Write data |
| wr_be_i | input | 4 | Byte enables for the write, bit n gates byte n |
| err_evt_i | input | 5 | Hardware error events that set the status flags |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | 32 | Registered read data |

## Verification
The bench sizes each window by writing all ones with partial and full byte enables. A design that stored the low bits, or lost the I/O indicator and ROM enable bits, would read back the wrong size mask. It makes an error event and a write-one clear collide in one cycle. A design that let the clear win would lose an error. It also reads an index in the same cycle it writes that index, expecting the old value, and switches the present input on and off in the middle of traffic. A design that leaked writes while the unit was absent, or returned its real identification, would show a difference against the bench model on the next read. Random writes to read-only and unused indices catch any decode that aliases them onto live registers.

// File: rtl/cfg_space_pkg.sv
package cfg_space_pkg;
  localparam int unsigned DW_BITS  = 32;
  localparam int unsigned ERR_BITS = 5;

  localparam int unsigned IDX_IDENT   = 0;
  localparam int unsigned IDX_CMDSTAT = 1;
  localparam int unsigned IDX_CLASS   = 2;
  localparam int unsigned IDX_MEMWIN  = 4;
  localparam int unsigned IDX_IOWIN   = 5;
  localparam int unsigned IDX_ROMWIN  = 12;

  function automatic logic [DW_BITS-1:0] byte_mask(input logic [3:0] be);
    logic [DW_BITS-1:0] m;
    for (int b = 0; b < 4; b++) m[b*8 +: 8] = {8{be[b]}};
    return m;
  endfunction
endpackage

// File: rtl/cfg_bar_reg.sv
module cfg_bar_reg
  import cfg_space_pkg::*;
#(
  parameter int unsigned        SIZE_LOG2 = 12,
  parameter logic [DW_BITS-1:0] TAG       = '0,
  parameter bit                 HAS_EN    = 1'b0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_sel,
  input  logic [DW_BITS-1:0] wdata,
  input  logic [3:0]         be,
  output logic [DW_BITS-1:0] value
);
  localparam logic [DW_BITS-1:0] HI_MASK = ~((DW_BITS'(1) << SIZE_LOG2) - DW_BITS'(1));
  localparam logic [DW_BITS-1:0] RW_MASK = HI_MASK | {{(DW_BITS-1){1'b0}}, HAS_EN};

  logic [DW_BITS-1:0] q;
  logic [DW_BITS-1:0] wmask;

  assign wmask = byte_mask(be) & RW_MASK;

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else if (wr_sel) q <= (q & ~wmask) | (wdata & wmask);
  end

  assign value = (q & RW_MASK) | TAG;
endmodule

// File: rtl/cfg_cmd_status.sv
module cfg_cmd_status
  import cfg_space_pkg::*;
#(
  parameter logic [15:0] CMD_MASK = 16'h0547
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_sel,
  input  logic [15:0]         cmd_wdata,
  input  logic [1:0]          cmd_be,
  input  logic [ERR_BITS-1:0] clr_wdata,
  input  logic                clr_be,
  input  logic [ERR_BITS-1:0] err_evt,
  output logic [15:0]         cmd,
  output logic [ERR_BITS-1:0] err
);
  logic [15:0]         cmd_wmask;
  logic [ERR_BITS-1:0] clr_bits;

  always_comb begin
    for (int b = 0; b < 2; b++) cmd_wmask[b*8 +: 8] = {8{cmd_be[b]}};
    cmd_wmask = cmd_wmask & CMD_MASK;
  end

  assign clr_bits = (wr_sel && clr_be) ? clr_wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd <= '0;
      err <= '0;
    end else begin
      if (wr_sel) cmd <= (cmd & ~cmd_wmask) | (cmd_wdata & cmd_wmask);
      err <= (err & ~clr_bits) | err_evt;
    end
  end
endmodule

// File: rtl/cfg_read_mux.sv
module cfg_read_mux
  import cfg_space_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID  = 16'h1A2B,
  parameter logic [15:0] DEVICE_ID  = 16'h0C3D,
  parameter logic [15:0] CLASS_CODE = 16'h0780,
  parameter logic [15:0] VENDOR_DEF = 16'h0005,
  parameter int unsigned IDX_W      = 6
) (
  input  logic [IDX_W-1:0]    idx,
  input  logic                present,
  input  logic [15:0]         cmd,
  input  logic [ERR_BITS-1:0] err,
  input  logic [DW_BITS-1:0]  mem_win,
  input  logic [DW_BITS-1:0]  io_win,
  input  logic [DW_BITS-1:0]  rom_win,
  output logic [DW_BITS-1:0]  data
);
  always_comb begin
    data = '0;
    if (!present) begin
      data = '1;
    end else begin
      case (int'(idx))
        IDX_IDENT:   data = {DEVICE_ID, VENDOR_ID};
        IDX_CMDSTAT: data = {err, {(16-ERR_BITS){1'b0}}, cmd};
        IDX_CLASS:   data = {CLASS_CODE, VENDOR_DEF};
        IDX_MEMWIN:  data = mem_win;
        IDX_IOWIN:   data = io_win;
        IDX_ROMWIN:  data = rom_win;
        default:     data = '0;
      endcase
    end
  end
endmodule

// File: rtl/cfg_space_regs.sv
module cfg_space_regs
  import cfg_space_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID  = 16'h1A2B,
  parameter logic [15:0] DEVICE_ID  = 16'h0C3D,
  parameter logic [15:0] CLASS_CODE = 16'h0780,
  parameter logic [15:0] VENDOR_DEF = 16'h0005,
  parameter logic [15:0] CMD_MASK   = 16'h0547,
  parameter int unsigned MEM_LOG2   = 12,
  parameter int unsigned IO_LOG2    = 8,
  parameter int unsigned ROM_LOG2   = 16,
  parameter int unsigned DW_COUNT   = 64,
  localparam int unsigned IDX_W     = $clog2(DW_COUNT)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                present_i,
  input  logic                rd_en_i,
  input  logic                wr_en_i,
  input  logic [IDX_W-1:0]    idx_i,
  input  logic [DW_BITS-1:0]  wr_data_i,
  input  logic [3:0]          wr_be_i,
  input  logic [ERR_BITS-1:0] err_evt_i,
  output logic                rd_valid_o,
  output logic [DW_BITS-1:0]  rd_data_o
);
  logic                wr_ok;
  logic [15:0]         cmd_q;
  logic [ERR_BITS-1:0] err_q;
  logic [DW_BITS-1:0]  mem_win, io_win, rom_win, rd_next;

  assign wr_ok = wr_en_i && present_i;

  cfg_cmd_status #(.CMD_MASK(CMD_MASK)) cmd_stat_i (
    .clk(clk), .rst(rst),
    .wr_sel(wr_ok && (int'(idx_i) == IDX_CMDSTAT)),
    .cmd_wdata(wr_data_i[15:0]), .cmd_be(wr_be_i[1:0]),
    .clr_wdata(wr_data_i[DW_BITS-1 -: ERR_BITS]), .clr_be(wr_be_i[3]),
    .err_evt(err_evt_i), .cmd(cmd_q), .err(err_q)
  );

  cfg_bar_reg #(.SIZE_LOG2(MEM_LOG2), .TAG('0), .HAS_EN(1'b0)) mem_win_i (
    .clk(clk), .rst(rst), .wr_sel(wr_ok && (int'(idx_i) == IDX_MEMWIN)),
    .wdata(wr_data_i), .be(wr_be_i), .value(mem_win)
  );

  cfg_bar_reg #(.SIZE_LOG2(IO_LOG2), .TAG(32'h1), .HAS_EN(1'b0)) io_win_i (
    .clk(clk), .rst(rst), .wr_sel(wr_ok && (int'(idx_i) == IDX_IOWIN)),
    .wdata(wr_data_i), .be(wr_be_i), .value(io_win)
  );

  cfg_bar_reg #(.SIZE_LOG2(ROM_LOG2), .TAG('0), .HAS_EN(1'b1)) rom_win_i (
    .clk(clk), .rst(rst), .wr_sel(wr_ok && (int'(idx_i) == IDX_ROMWIN)),
    .wdata(wr_data_i), .be(wr_be_i), .value(rom_win)
  );

  cfg_read_mux #(
    .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID), .CLASS_CODE(CLASS_CODE),
    .VENDOR_DEF(VENDOR_DEF), .IDX_W(IDX_W)
  ) rd_mux_i (
    .idx(idx_i), .present(present_i), .cmd(cmd_q), .err(err_q),
    .mem_win(mem_win), .io_win(io_win), .rom_win(rom_win), .data(rd_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= rd_en_i;
      if (rd_en_i) rd_data_o <= rd_next;
    end
  end
endmodule

// File: rtl/cfg_space_chk.sv
module cfg_space_chk
  import cfg_space_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID = 16'h1A2B,
  parameter logic [15:0] DEVICE_ID = 16'h0C3D,
  parameter int unsigned MEM_LOG2  = 12,
  parameter int unsigned IDX_W     = 6
) (
  input logic                clk,
  input logic                rst,
  input logic                present_i,
  input logic                rd_en_i,
  input logic [IDX_W-1:0]    idx_i,
  input logic [ERR_BITS-1:0] err_evt_i,
  input logic [ERR_BITS-1:0] err_q,
  input logic                rd_valid_o,
  input logic [DW_BITS-1:0]  rd_data_o
);
  localparam logic [DW_BITS-1:0] MEM_LOW = (DW_BITS'(1) << MEM_LOG2) - DW_BITS'(1);

  // R11
  rd_valid_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en_i |=> rd_valid_o);
  // R11
  rd_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en_i |=> (!rd_valid_o && $stable(rd_data_o)));
  // R3
  absent_ones_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && !present_i) |=> (rd_data_o == '1));
  // R2
  ident_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && present_i && idx_i == '0) |=> (rd_data_o == {DEVICE_ID, VENDOR_ID}));
  // R6
  err_set_chk: assert property (@(posedge clk) disable iff (rst)
    (|err_evt_i) |=> ((err_q & $past(err_evt_i)) == $past(err_evt_i)));
  // R7
  mem_low_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && present_i && int'(idx_i) == IDX_MEMWIN) |=> ((rd_data_o & MEM_LOW) == '0));
  // R10
  high_region_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && present_i && int'(idx_i) >= 16) |=> (rd_data_o == '0));
endmodule

bind cfg_space_regs cfg_space_chk #(
  .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID), .MEM_LOG2(MEM_LOG2), .IDX_W(IDX_W)
) chk_i (
  .clk(clk), .rst(rst), .present_i(present_i), .rd_en_i(rd_en_i), .idx_i(idx_i),
  .err_evt_i(err_evt_i), .err_q(err_q), .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o)
);

// File: tb/cfg_space_regs_tb_top.sv
module cfg_space_regs_tb_top;
  localparam logic [15:0] VEN = 16'h1A2B, DEV = 16'h0C3D, CLS = 16'h0780, VDEF = 16'h0005;
  localparam logic [15:0] CMASK = 16'h0547;
  localparam logic [31:0] MEM_RW = 32'hFFFF_F000;
  localparam logic [31:0] IO_RW  = 32'hFFFF_FF00;
  localparam logic [31:0] ROM_RW = 32'hFFFF_0001;

  logic clk = 1'b0, rst = 1'b1, present = 1'b1, rd_en = 1'b0, wr_en = 1'b0;
  logic [5:0] idx = '0;
  logic [31:0] wdata = '0;
  logic [3:0] be = '0;
  logic [4:0] evt = '0;
  logic rd_valid;
  logic [31:0] rd_data;

  int vectors = 0, miscompares = 0;
  bit done = 1'b0;

  logic        pres_m = 1'b1;
  logic [15:0] cmd_m = '0;
  logic [4:0]  err_m = '0;
  logic [31:0] mem_m = '0, io_m = '0, rom_m = '0, last_rd = '0;

  always #4 clk = ~clk;

  cfg_space_regs dut_i (
    .clk(clk), .rst(rst), .present_i(present), .rd_en_i(rd_en), .wr_en_i(wr_en),
    .idx_i(idx), .wr_data_i(wdata), .wr_be_i(be), .err_evt_i(evt),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data)
  );

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] d,
                                        input logic [3:0] b, input logic [31:0] rw);
    logic [31:0] m;
    for (int k = 0; k < 4; k++) m[k*8 +: 8] = {8{b[k]}};
    m = m & rw;
    return (old & ~m) | (d & m);
  endfunction

  function automatic logic [31:0] exp_rd(input logic [5:0] ix);
    if (!pres_m) return 32'hFFFF_FFFF;
    case (ix)
      6'd0:    return {DEV, VEN};
      6'd1:    return {err_m, 11'b0, cmd_m};
      6'd2:    return {CLS, VDEF};
      6'd4:    return mem_m;
      6'd5:    return io_m | 32'h1;
      6'd12:   return rom_m;
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // Called at a negedge; returns at the following negedge.
  task automatic op(input bit rd, input bit wr, input logic [5:0] ix, input logic [31:0] d,
                    input logic [3:0] b, input logic [4:0] ev, input string tag);
    logic [31:0] e;
    logic [4:0] clr;
    e = exp_rd(ix);
    rd_en = rd; wr_en = wr; idx = ix; wdata = d; be = b; evt = ev;
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0; evt = '0;
    clr = '0;
    if (wr && pres_m) begin
      case (ix)
        6'd1: begin
          cmd_m = merge({16'h0, cmd_m}, {16'h0, d[15:0]}, b, {16'h0, CMASK})[15:0];
          if (b[3]) clr = d[31:27];
        end
        6'd4:  mem_m = merge(mem_m, d, b, MEM_RW);
        6'd5:  io_m  = merge(io_m, d, b, IO_RW);
        6'd12: rom_m = merge(rom_m, d, b, ROM_RW);
        default: ;
      endcase
    end
    err_m = (err_m & ~clr) | ev;
    if (rd) begin
      chk(rd_data == e, tag, rd_data, e);
      chk(rd_valid == 1'b1, "R11 valid after read", {31'b0, rd_valid}, 32'h1);
      last_rd = e;
    end else begin
      chk(rd_valid == 1'b0 && rd_data == last_rd, "R11 hold without read", rd_data, last_rd);
    end
  endtask

  task automatic set_present(input logic v);
    present = v; pres_m = v;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", vectors, 0);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1D0C));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(rd_valid == 1'b0 && rd_data == 32'h0, "R1 outputs after reset", rd_data, 32'h0);
    op(1, 0, 6'd1, '0, '0, '0, "R1 command/status reset");
    op(1, 0, 6'd4, '0, '0, '0, "R1 memory window reset");
    op(1, 0, 6'd5, '0, '0, '0, "R1 io window reset");
    op(1, 0, 6'd12, '0, '0, '0, "R1 rom window reset");
    // R2 identification, R4 class
    op(1, 0, 6'd0, '0, '0, '0, "R2 ident read");
    op(0, 1, 6'd0, 32'h0, 4'hF, '0, "R2 ident write");
    op(1, 0, 6'd0, '0, '0, '0, "R2 ident unchanged after write");
    op(0, 1, 6'd2, 32'h1234_5678, 4'hF, '0, "R4 class write");
    op(1, 0, 6'd2, '0, '0, '0, "R4 class read");
    // R7 R8 R9 sizing with all ones
    op(0, 1, 6'd4, 32'hFFFF_FFFF, 4'hF, '0, "R7 size write");
    op(1, 0, 6'd4, '0, '0, '0, "R7 memory size mask");
    op(0, 1, 6'd5, 32'hFFFF_FFFF, 4'hF, '0, "R8 size write");
    op(1, 0, 6'd5, '0, '0, '0, "R8 io size mask");
    op(0, 1, 6'd12, 32'hFFFF_FFFF, 4'hF, '0, "R9 size write");
    op(1, 0, 6'd12, '0, '0, '0, "R9 rom size mask");
    op(0, 1, 6'd4, 32'h0000_0000, 4'b0100, '0, "R7 partial byte write");
    op(1, 0, 6'd4, '0, '0, '0, "R7 partial byte result");
    // R5 command
    op(0, 1, 6'd1, 32'h0000_FFFF, 4'b0001, '0, "R5 low byte write");
    op(1, 0, 6'd1, '0, '0, '0, "R5 command low byte");
    op(0, 1, 6'd1, 32'h0000_FFFF, 4'b0010, '0, "R5 high byte write");
    op(1, 0, 6'd1, '0, '0, '0, "R5 command masked");
    // R6 set, clear, zero no effect, set wins
    op(0, 0, 6'd1, '0, '0, 5'b10101, "R6 events");
    op(1, 0, 6'd1, '0, '0, '0, "R6 flags set");
    op(0, 1, 6'd1, 32'h0000_0000, 4'b1000, '0, "R6 write zero");
    op(1, 0, 6'd1, '0, '0, '0, "R6 zero write keeps flags");
    op(0, 1, 6'd1, 32'h2800_0000, 4'b0111, '0, "R6 clear without byte 3");
    op(1, 0, 6'd1, '0, '0, '0, "R6 flags kept without byte enable");
    op(0, 1, 6'd1, 32'hF800_0000, 4'b1000, 5'b00001, "R6 set vs clear");
    op(1, 0, 6'd1, '0, '0, '0, "R6 set wins over clear");
    // R11 read and write same index
    op(1, 1, 6'd5, 32'h0000_AB00, 4'hF, '0, "R11 read during write returns old");
    op(1, 0, 6'd5, '0, '0, '0, "R11 write visible after");
    // R10 unused index
    op(0, 1, 6'd3, 32'hFFFF_FFFF, 4'hF, '0, "R10 write hole");
    op(1, 0, 6'd3, '0, '0, '0, "R10 header hole reads zero");
    op(0, 1, 6'd40, 32'hFFFF_FFFF, 4'hF, '0, "R10 write high");
    op(1, 0, 6'd40, '0, '0, '0, "R10 high region reads zero");
    op(1, 0, 6'd4, '0, '0, '0, "R10 memory window untouched");
    // R3 absent unit
    set_present(1'b0);
    op(1, 0, 6'd0, '0, '0, '0, "R3 absent ident");
    op(0, 1, 6'd4, 32'h1234_5000, 4'hF, '0, "R3 absent write");
    op(1, 0, 6'd4, '0, '0, '0, "R3 absent window read");
    set_present(1'b1);
    op(1, 0, 6'd4, '0, '0, '0, "R3 write ignored while absent");
    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [5:0] ix;
      int unsigned r;
      r = $urandom % 16;
      case ($urandom % 4)
        0: ix = 6'($urandom % 64);
        1: ix = 6'd1;
        2: ix = 6'($urandom % 3);
        default: ix = (r[0]) ? 6'd4 : ((r[1]) ? 6'd5 : 6'd12);
      endcase
      if (r == 15) set_present(~pres_m);
      op(r[2] | r[3], r[1] | r[3], ix, $urandom, 4'($urandom), (r < 3) ? 5'($urandom) : 5'd0,
         "R5 R6 R7 R8 R9 random mix");
    end
    set_present(1'b1);
    op(1, 0, 6'd1, '0, '0, '0, "R6 final status");
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule